// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the device-side register file of an ATA disk interface. A host bus reaches it through a 3-bit register address with separate read and write strobes. The block keeps the shadow registers a host programs before it issues a command: the sector count, the three LBA bytes and the device/head byte. Offset 7 works in both directions: a read returns the status byte and a write issues a command.

A small sequencer runs the accepted command and moves the status byte through its phases. IDENTIFY gives the host 256 words of device information through the data register, which is read by PIO. FLUSH CACHE holds the device busy until an external completion strobe arrives. READ DMA and WRITE DMA hand the transfer to an outside DMA engine with a one-cycle start pulse and a direction bit, and they stay busy until that engine reports done. The block raises an interrupt request line when a command completes or fails. A read of the status register clears that line.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After synchronous reset the status byte (offset 7) reads 0x40, with only DRDY (bit 6) set. `irq` is low, and the shadow registers at offsets 2 to 6 read 0.
- R2: A write to offset 2 (sector count), 3 (LBA low), 4 (LBA mid), 5 (LBA high) or 6 (device) stores the byte, and a read of the same offset returns it in `rd_data[7:0]` with the upper byte zero. Device bit 4 (drive select) and bit 6 (LBA mode) are kept exactly as written.
- R3: Command 0xEC (IDENTIFY) enters a data phase in which status reads 0x48 (DRDY plus DRQ, bit 3). The phase lasts for 256 reads of offset 0. After the 256th read, status reads 0x40.
- R4: During IDENTIFY, data word i read at offset 0 is 0x0040 for i=0 and 0x0020 for i=85 (bit 5: write cache enabled). Every other word is {~i[7:0], i[7:0]}. Offset 0 reads 0 outside the data phase.
- R5: Command 0xE7 (FLUSH CACHE) gives a one-cycle `flush_start` pulse. Status then reads 0xC0 (BSY bit 7 plus DRDY) until a `flush_done` cycle, and reads 0x40 after it.
- R6: Commands 0xC8 (READ DMA) and 0xCA (WRITE DMA) give a one-cycle `dma_start` pulse. `dma_to_host` is 1 for 0xC8 and 0 for 0xCA. Status reads 0xC0 until a `dma_done` cycle, then 0x40.
- R7: Any other command code, 0xA0 (PACKET) included, sets ERR. Status then reads 0x41, offset 1 reads 0x04 (abort bit 2), and `irq` rises. The next accepted command clears ERR.
- R8: A command write while BSY is set is ignored: state, status and strobes do not change.
- R9: `irq` rises when IDENTIFY data becomes ready, when a flush or DMA command completes, and when a command is rejected. A read of offset 7 clears it unless a new interrupt event occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read side effects take place at the clock edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 16 | Read data (combinational from reg_addr) |
| irq | output | 1 | Interrupt request |
| flush_start | output | 1 | One-cycle flush request |
| flush_done | input | 1 | Flush completion strobe |
| dma_start | output | 1 | One-cycle DMA handoff |
| dma_to_host | output | 1 | DMA direction, 1 = device to host |
| dma_done | input | 1 | DMA completion strobe |

## Verification
The assertions assume three things about the inputs. `flush_done` and `dma_done` arrive only while the matching command is outstanding. A read and a write never share a cycle. Reads of offset 0 happen only while DRQ is shown or are harmless. The bench respects all three: it pulses each done strobe only after it has seen BSY, it drives one strobe per task, and it reads data words only inside the IDENTIFY phase, apart from one deliberate idle read that checks the zero return.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
    localparam int REG_W    = 8;
    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 3;
    localparam int ID_WORDS = 256;
    localparam int IDX_W    = $clog2(ID_WORDS);

    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_ERR  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_LBA0 = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_LBA1 = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_LBA2 = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_DEV  = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 3'd7;

    localparam logic [REG_W-1:0] OP_READ_DMA  = 8'hC8;
    localparam logic [REG_W-1:0] OP_WRITE_DMA = 8'hCA;
    localparam logic [REG_W-1:0] OP_FLUSH     = 8'hE7;
    localparam logic [REG_W-1:0] OP_IDENT     = 8'hEC;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_IDENT,
        SQ_FLUSH,
        SQ_DMA
    } seq_state_e;

    typedef struct packed {
        logic bsy;
        logic drdy;
        logic df;
        logic rsv4;
        logic drq;
        logic rsv2;
        logic rsv1;
        logic err;
    } status_t;

    typedef struct packed {
        logic [REG_W-1:0] cnt;
        logic [REG_W-1:0] lba0;
        logic [REG_W-1:0] lba1;
        logic [REG_W-1:0] lba2;
        logic [REG_W-1:0] dev;
    } shadow_t;

    function automatic logic [WORD_W-1:0] ident_word(input logic [IDX_W-1:0] idx);
        logic [7:0] lo;
        lo = 8'(idx);
        if (idx == IDX_W'(0))       return 16'h0040;
        else if (idx == IDX_W'(85)) return 16'h0020;
        else                        return {~lo, lo};
    endfunction
endpackage

// File: rtl/ata_tf_shadow.sv
module ata_tf_shadow
    import ata_tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output shadow_t           regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr) begin
            case (addr)
                OFS_CNT:  regs.cnt  <= wdata;
                OFS_LBA0: regs.lba0 <= wdata;
                OFS_LBA1: regs.lba1 <= wdata;
                OFS_LBA2: regs.lba2 <= wdata;
                OFS_DEV:  regs.dev  <= wdata;
                default:  ;
            endcase
        end
    end

    // R2: a write elsewhere leaves the count register alone
    a_r2_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        (wr && addr != OFS_CNT) |=> $stable(regs.cnt));
endmodule

// File: rtl/ata_tf_idrom.sv
module ata_tf_idrom
    import ata_tf_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);
    always_comb word = ident_word(idx);
endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
    import ata_tf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [REG_W-1:0] cmd_code,
    input  logic             data_rd,
    input  logic             status_rd,
    input  logic             flush_done,
    input  logic             dma_done,
    output status_t          status,
    output logic             irq,
    output logic [IDX_W-1:0] widx,
    output logic             flush_start,
    output logic             dma_start,
    output logic             dma_to_host
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_WORDS - 1);

    seq_state_e st;
    logic       err;
    logic       busy;
    logic       accept;

    assign busy   = (st == SQ_FLUSH) || (st == SQ_DMA);
    assign accept = cmd_wr && !busy;

    always_comb begin
        status      = '0;
        status.bsy  = busy;
        status.drdy = 1'b1;
        status.drq  = (st == SQ_IDENT);
        status.err  = err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= SQ_IDLE;
            err         <= 1'b0;
            irq         <= 1'b0;
            widx        <= '0;
            flush_start <= 1'b0;
            dma_start   <= 1'b0;
            dma_to_host <= 1'b0;
        end else begin
            flush_start <= 1'b0;
            dma_start   <= 1'b0;
            if (status_rd) irq <= 1'b0;
            if (accept) begin
                err  <= 1'b0;
                widx <= '0;
                case (cmd_code)
                    OP_IDENT: begin
                        st  <= SQ_IDENT;
                        irq <= 1'b1;
                    end
                    OP_FLUSH: begin
                        st          <= SQ_FLUSH;
                        flush_start <= 1'b1;
                    end
                    OP_READ_DMA: begin
                        st          <= SQ_DMA;
                        dma_start   <= 1'b1;
                        dma_to_host <= 1'b1;
                    end
                    OP_WRITE_DMA: begin
                        st          <= SQ_DMA;
                        dma_start   <= 1'b1;
                        dma_to_host <= 1'b0;
                    end
                    default: begin
                        st  <= SQ_IDLE;
                        err <= 1'b1;
                        irq <= 1'b1;
                    end
                endcase
            end else begin
                case (st)
                    SQ_IDENT: if (data_rd) begin
                        if (widx == LAST_IDX) begin
                            st   <= SQ_IDLE;
                            widx <= '0;
                        end else begin
                            widx <= widx + 1'b1;
                        end
                    end
                    SQ_FLUSH: if (flush_done) begin
                        st  <= SQ_IDLE;
                        irq <= 1'b1;
                    end
                    SQ_DMA: if (dma_done) begin
                        st  <= SQ_IDLE;
                        irq <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: the last data word closes the phase
    a_r3_ident_end: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDENT && data_rd && !cmd_wr && widx == LAST_IDX) |=> (st == SQ_IDLE && !status.drq));
    // R5: flush request is a single-cycle pulse
    a_r5_flush_pulse: assert property (@(posedge clk) disable iff (rst)
        flush_start |=> !flush_start);
    // R6: DMA handoff coincides with busy
    a_r6_dma_busy: assert property (@(posedge clk) disable iff (rst)
        dma_start |-> status.bsy);
    // R8: a pending flush survives command writes
    a_r8_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_FLUSH && !flush_done) |=> (st == SQ_FLUSH));
    // R9: status read in idle with no new command drops the request
    a_r9_irq_clear: assert property (@(posedge clk) disable iff (rst)
        (status_rd && st == SQ_IDLE && !cmd_wr) |=> !irq);
endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
    import ata_tf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  wr_data,
    output logic [15:0] rd_data,
    output logic        irq,
    output logic        flush_start,
    input  logic        flush_done,
    output logic        dma_start,
    output logic        dma_to_host,
    input  logic        dma_done
);
    shadow_t           regs;
    status_t           status;
    logic [IDX_W-1:0]  widx;
    logic [WORD_W-1:0] id_word;
    logic              cmd_wr, data_rd, status_rd;

    assign cmd_wr    = reg_wr && (reg_addr == OFS_CMD);
    assign data_rd   = reg_rd && (reg_addr == OFS_DATA);
    assign status_rd = reg_rd && (reg_addr == OFS_CMD);

    ata_tf_shadow u_shadow (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
        .wdata(wr_data), .regs(regs)
    );

    ata_tf_idrom u_rom (.idx(widx), .word(id_word));

    ata_tf_seq u_seq (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_code(wr_data),
        .data_rd(data_rd), .status_rd(status_rd),
        .flush_done(flush_done), .dma_done(dma_done),
        .status(status), .irq(irq), .widx(widx),
        .flush_start(flush_start), .dma_start(dma_start),
        .dma_to_host(dma_to_host)
    );

    always_comb begin
        rd_data = '0;
        case (reg_addr)
            OFS_DATA: rd_data = status.drq ? id_word : '0;
            OFS_ERR:  rd_data = {13'd0, status.err, 2'b00};
            OFS_CNT:  rd_data = {8'd0, regs.cnt};
            OFS_LBA0: rd_data = {8'd0, regs.lba0};
            OFS_LBA1: rd_data = {8'd0, regs.lba1};
            OFS_LBA2: rd_data = {8'd0, regs.lba2};
            OFS_DEV:  rd_data = {8'd0, regs.dev};
            default:  rd_data = {8'd0, status};
        endcase
    end
endmodule

// File: tb/ata_taskfile_ctrl_tb.sv
module ata_taskfile_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  reg_addr;
    logic        reg_wr, reg_rd;
    logic [7:0]  wr_data;
    logic [15:0] rd_data;
    logic        irq, flush_start, flush_done, dma_start, dma_to_host, dma_done;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_taskfile_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
        .flush_start(flush_start), .flush_done(flush_done),
        .dma_start(dma_start), .dma_to_host(dma_to_host), .dma_done(dma_done)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        reg_rd = 1'b0;
        #1;
    endtask

    function automatic logic [15:0] exp_word(input int i);
        logic [7:0] b;
        b = 8'(i);
        if (i == 0) return 16'h0040;
        if (i == 85) return 16'h0020;
        return {~b, b};
    endfunction

    task automatic t_reset;
        logic [15:0] v;
        chk("R1 irq", {15'd0, irq}, 16'h0);
        rd_reg(3'd7, v); chk("R1 status", v, 16'h0040);
        for (int a = 2; a <= 6; a++) begin
            rd_reg(3'(a), v); chk("R1 shadow", v, 16'h0);
        end
    endtask

    task automatic t_shadow;
        logic [15:0] v;
        wr_reg(3'd2, 8'h11); wr_reg(3'd3, 8'h22); wr_reg(3'd4, 8'h33);
        wr_reg(3'd5, 8'h44); wr_reg(3'd6, 8'h50);
        rd_reg(3'd2, v); chk("R2 count", v, 16'h0011);
        rd_reg(3'd3, v); chk("R2 lba low", v, 16'h0022);
        rd_reg(3'd4, v); chk("R2 lba mid", v, 16'h0033);
        rd_reg(3'd5, v); chk("R2 lba high", v, 16'h0044);
        rd_reg(3'd6, v); chk("R2 device", v, 16'h0050);
    endtask

    task automatic t_identify;
        logic [15:0] v;
        rd_reg(3'd0, v); chk("R4 idle data", v, 16'h0);
        wr_reg(3'd7, 8'hEC);
        chk("R9 irq ident", {15'd0, irq}, 16'h1);
        for (int i = 0; i < 256; i++) begin
            rd_reg(3'd7, v); chk("R3 status in phase", v, 16'h0048);
            if (i == 0) chk("R9 irq cleared", {15'd0, irq}, 16'h0);
            rd_reg(3'd0, v); chk("R4 word", v, exp_word(i));
        end
        rd_reg(3'd7, v); chk("R3 status after", v, 16'h0040);
    endtask

    task automatic t_flush;
        logic [15:0] v;
        wr_reg(3'd7, 8'hE7);
        chk("R5 flush_start", {15'd0, flush_start}, 16'h1);
        rd_reg(3'd7, v); chk("R5 busy status", v, 16'h00C0);
        chk("R5 pulse one cycle", {15'd0, flush_start}, 16'h0);
        wr_reg(3'd7, 8'hEC);
        chk("R8 no start", {15'd0, flush_start}, 16'h0);
        rd_reg(3'd7, v); chk("R8 still busy", v, 16'h00C0);
        @(negedge clk); flush_done = 1'b1;
        @(negedge clk); flush_done = 1'b0;
        chk("R9 irq flush", {15'd0, irq}, 16'h1);
        rd_reg(3'd7, v); chk("R5 done status", v, 16'h0040);
        chk("R9 irq clear", {15'd0, irq}, 16'h0);
    endtask

    task automatic t_dma(input logic [7:0] op, input logic dir);
        logic [15:0] v;
        wr_reg(3'd7, op);
        chk("R6 dma_start", {15'd0, dma_start}, 16'h1);
        chk("R6 direction", {15'd0, dma_to_host}, {15'd0, dir});
        rd_reg(3'd7, v); chk("R6 busy status", v, 16'h00C0);
        wr_reg(3'd7, 8'hE7);
        chk("R8 no flush", {15'd0, flush_start}, 16'h0);
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
        chk("R9 irq dma", {15'd0, irq}, 16'h1);
        rd_reg(3'd7, v); chk("R6 done status", v, 16'h0040);
    endtask

    task automatic t_bad(input logic [7:0] op);
        logic [15:0] v;
        wr_reg(3'd7, op);
        chk("R7 irq", {15'd0, irq}, 16'h1);
        rd_reg(3'd1, v); chk("R7 abort bit", v, 16'h0004);
        rd_reg(3'd7, v); chk("R7 status", v, 16'h0041);
        wr_reg(3'd7, 8'hE7);
        rd_reg(3'd7, v); chk("R7 err cleared", v, 16'h00C0);
        @(negedge clk); flush_done = 1'b1;
        @(negedge clk); flush_done = 1'b0;
        rd_reg(3'd7, v);
    endtask

    initial begin
        rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; wr_data = '0;
        flush_done = 1'b0; dma_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_shadow();
        t_identify();
        t_flush();
        t_dma(8'hC8, 1'b1);
        t_dma(8'hCA, 1'b0);
        t_bad(8'h00);
        t_bad(8'hA0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule